// File: doc/BRIEF.md
# Snooping MESI Line State Controller

This block is the coherence controller of a small direct-mapped write-back data cache that shares an arbitrated snooping bus with other caches. Every line carries one of four permission states: invalid, shared, exclusive or modified. Loads and stores arrive one at a time from the local core. A miss, an upgrade or an eviction raises a bus request. That request proceeds only when the bus grants it, and the whole transaction completes in the grant cycle. In that same cycle every other cache sees the transaction on its snoop port and answers it combinationally.

When a snooped transaction hits a line held here, the controller asserts a shared response and updates the line state. If the line is dirty, it also drives the whole line onto its memory write-back port, so memory, or the requesting cache, receives current data before the line gives up ownership. Stores complete only while the line is owned, meaning exclusive or modified. A store to an exclusive line upgrades it without bus traffic. A store in any other state first takes a read-exclusive on the bus.

Top module: `mesi_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses. `core_req_ready` is 1, and `bus_req`, `core_rsp_valid` and `mem_wb_valid` are 0.
- R2: A read whose line is absent or invalid raises `bus_req` with `bus_cmd` = 1 (read) for the line address. In the grant cycle the line fills from `bus_rline` in the exclusive state when `bus_shared_in` is 0, and in the shared state when it is 1. The requested word is returned.
- R3: A read that hits a line in the shared, exclusive or modified state returns the stored word with no bus request. `core_rsp_valid` pulses for one cycle with the data.
- R4: A write that hits an exclusive line completes with no bus request and leaves the line modified.
- R5: A write whose line is invalid, absent or shared raises `bus_cmd` = 2 (read-exclusive). In the grant cycle the written word is merged into the fetched line, and the line becomes modified.
- R6: A snooped read (`snp_cmd` = 1) that hits a valid line asserts `snp_shared` and moves an exclusive or modified line to shared. A modified line also drives `mem_wb_valid` with its address and data in that cycle.
- R7: A snooped read-exclusive (`snp_cmd` = 2) that hits a valid line asserts `snp_shared` and invalidates the line. A modified line also drives its data on the write-back port in that cycle.
- R8: A miss whose indexed slot holds a modified line with a different tag first issues `bus_cmd` = 3 (write-back) for the victim address and data, and only then issues the fill. A clean victim is replaced with no write-back. If a snoop cleans the victim while the request is waiting, the write-back is dropped.
- R9: Once raised, `bus_req` stays high until `bus_gnt`. No fill, upgrade or eviction takes effect without a grant.
- R10: `core_req_ready` is low from the accepting cycle until the cycle in which `core_rsp_valid` pulses.
- R11: Across caches on one bus, a read returns the value of the most recent write to that address by any core. A line owned by one cache is never valid in another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_valid | input | 1 | Core request present |
| core_req_write | input | 1 | 1 = store, 0 = load |
| core_req_addr | input | ADDR_W | Byte address of the word |
| core_req_wdata | input | WORD_W | Store data |
| core_req_ready | output | 1 | Controller can accept a request |
| core_rsp_valid | output | 1 | One-cycle completion pulse |
| core_rsp_rdata | output | WORD_W | Load data |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 1 read, 2 read-exclusive, 3 write-back |
| bus_addr | output | ADDR_W | Line address of the transaction |
| bus_wline | output | LINE_BYTES*8 | Victim line data for write-back |
| bus_gnt | input | 1 | Grant; the transaction completes this cycle |
| bus_rline | input | LINE_BYTES*8 | Line data returned for a read |
| bus_shared_in | input | 1 | Another cache holds the line |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds the snooped line valid |
| mem_wb_valid | output | 1 | Dirty line supplied on a snoop hit |
| mem_wb_addr | output | ADDR_W | Line address of the supplied data |
| mem_wb_line | output | LINE_BYTES*8 | Supplied line data |

## Verification
The hardest case to reach is a cache whose eviction write-back is waiting for the bus while the winning cache's read snoops that very victim. The victim is flushed and downgraded, so the pending write-back must turn into a plain fill. The bench first makes one cache own a line. It then issues, in the same cycle, a read of that line from the higher-priority cache and a conflicting-tag read from the owner. The bench's model expects the owner's only bus transaction to be the read. Simultaneous misses on both caches also check that the waiting request is held and that its command reflects the state left by the winner.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_state_e;

  typedef enum logic [1:0] {
    BC_IDLE  = 2'd0,
    BC_READ  = 2'd1,
    BC_READX = 2'd2,
    BC_WBACK = 2'd3
  } bus_cmd_e;

  function automatic logic is_owned(line_state_e s);
    return (s == LS_EXC) || (s == LS_MOD);
  endfunction
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int TAG_W   = 22,
  parameter int LINE_W  = 512,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [IDX_W-1:0]  sn_idx,
  input  logic              cw_en,
  input  logic [IDX_W-1:0]  cw_idx,
  input  line_state_e       cw_state,
  input  logic [TAG_W-1:0]  cw_tag,
  input  logic [LINE_W-1:0] cw_line,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  line_state_e       sw_state,
  output line_state_e       lk_state,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [LINE_W-1:0] lk_line,
  output line_state_e       sn_state,
  output logic [TAG_W-1:0]  sn_tag,
  output logic [LINE_W-1:0] sn_line
);
  line_state_e       st_v  [N_LINES];
  logic [TAG_W-1:0]  tag_v [N_LINES];
  logic [LINE_W-1:0] dat_v [N_LINES];

  for (genvar g = 0; g < N_LINES; g++) begin : g_ent
    line_state_e       st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [LINE_W-1:0] dat_r;
    logic              core_w, snoop_w;

    assign core_w  = cw_en && (cw_idx == IDX_W'(g));
    assign snoop_w = sw_en && (sw_idx == IDX_W'(g));

    // snoop updates win over a same-cycle local update of the entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st_r <= LS_INV;
      else if (snoop_w) st_r <= sw_state;
      else if (core_w)  st_r <= cw_state;
    end

    always_ff @(posedge clk) begin
      if (core_w && !snoop_w) begin
        tag_r <= cw_tag;
        dat_r <= cw_line;
      end
    end

    assign st_v[g]  = st_r;
    assign tag_v[g] = tag_r;
    assign dat_v[g] = dat_r;
  end

  assign lk_state = st_v[lk_idx];
  assign lk_tag   = tag_v[lk_idx];
  assign lk_line  = dat_v[lk_idx];
  assign sn_state = st_v[sn_idx];
  assign sn_tag   = tag_v[sn_idx];
  assign sn_line  = dat_v[sn_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W = 22
) (
  input  logic             snp_valid,
  input  bus_cmd_e         snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_state_e      held_state,
  input  logic [TAG_W-1:0] held_tag,
  output logic             hit,
  output logic             upd_en,
  output line_state_e      upd_state,
  output logic             flush
);
  always_comb begin
    hit       = snp_valid && (held_state != LS_INV) && (held_tag == snp_tag);
    upd_en    = 1'b0;
    upd_state = held_state;
    flush     = 1'b0;
    if (hit) begin
      unique case (snp_cmd)
        BC_READ: begin
          flush = (held_state == LS_MOD);
          if (is_owned(held_state)) begin
            upd_en    = 1'b1;
            upd_state = LS_SHR;
          end
        end
        BC_READX: begin
          flush     = (held_state == LS_MOD);
          upd_en    = 1'b1;
          upd_state = LS_INV;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int N_LINES    = 16,
  parameter int WORD_W     = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    core_req_valid,
  input  logic                    core_req_write,
  input  logic [ADDR_W-1:0]       core_req_addr,
  input  logic [WORD_W-1:0]       core_req_wdata,
  output logic                    core_req_ready,
  output logic                    core_rsp_valid,
  output logic [WORD_W-1:0]       core_rsp_rdata,
  output logic                    bus_req,
  output logic [1:0]              bus_cmd,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [LINE_BYTES*8-1:0] bus_wline,
  input  logic                    bus_gnt,
  input  logic [LINE_BYTES*8-1:0] bus_rline,
  input  logic                    bus_shared_in,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [ADDR_W-1:0]       snp_addr,
  output logic                    snp_shared,
  output logic                    mem_wb_valid,
  output logic [ADDR_W-1:0]       mem_wb_addr,
  output logic [LINE_BYTES*8-1:0] mem_wb_line
);
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int IDX_W    = $clog2(N_LINES);
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W   = LINE_BYTES * 8;
  localparam int WSEL_W   = $clog2(LINE_W / WORD_W);
  localparam int BYTE_OFF = $clog2(WORD_W / 8);

  function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WSEL_W-1:0] wsel_of(logic [ADDR_W-1:0] a);
    return a[BYTE_OFF +: WSEL_W];
  endfunction
  function automatic logic [ADDR_W-1:0] line_base(logic [TAG_W-1:0] t, logic [IDX_W-1:0] i);
    return {t, i, {OFF_W{1'b0}}};
  endfunction
  function automatic logic [WORD_W-1:0] word_get(logic [LINE_W-1:0] l, logic [WSEL_W-1:0] s);
    return l[s*WORD_W +: WORD_W];
  endfunction
  function automatic logic [LINE_W-1:0] word_put(logic [LINE_W-1:0] l, logic [WSEL_W-1:0] s,
                                                 logic [WORD_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = l;
    r[s*WORD_W +: WORD_W] = w;
    return r;
  endfunction

  // request registers
  logic              busy_q, rq_wr_q, rsp_valid_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic [WORD_W-1:0] rq_wdata_q, rsp_rdata_q;

  // named internal events
  logic              accept, lk_hit, local_ok, local_done, need_bus, granted;
  logic              victim_dirty, fill_done, done;
  bus_cmd_e          cmd_w;
  logic [IDX_W-1:0]  r_idx, sn_idx;
  logic [TAG_W-1:0]  r_tag;
  logic [WSEL_W-1:0] r_sel;

  line_state_e       lk_state, sn_state, cw_state, sw_state;
  logic [TAG_W-1:0]  lk_tag, sn_tag, cw_tag;
  logic [LINE_W-1:0] lk_line, sn_line, cw_line;
  logic              cw_en, sw_en, sn_hit, sn_flush;
  logic [WORD_W-1:0] rdata_next;

  assign r_idx = idx_of(rq_addr_q);
  assign r_tag = tag_of(rq_addr_q);
  assign r_sel = wsel_of(rq_addr_q);
  assign sn_idx = idx_of(snp_addr);

  mesi_line_store #(.N_LINES(N_LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(r_idx), .sn_idx(sn_idx),
    .cw_en(cw_en), .cw_idx(r_idx), .cw_state(cw_state), .cw_tag(cw_tag), .cw_line(cw_line),
    .sw_en(sw_en), .sw_idx(sn_idx), .sw_state(sw_state),
    .lk_state(lk_state), .lk_tag(lk_tag), .lk_line(lk_line),
    .sn_state(sn_state), .sn_tag(sn_tag), .sn_line(sn_line)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W)) snoop_i (
    .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)), .snp_tag(tag_of(snp_addr)),
    .held_state(sn_state), .held_tag(sn_tag),
    .hit(sn_hit), .upd_en(sw_en), .upd_state(sw_state), .flush(sn_flush)
  );

  // local side
  assign accept       = core_req_valid && !busy_q;
  assign lk_hit       = (lk_state != LS_INV) && (lk_tag == r_tag);
  assign local_ok     = lk_hit && (!rq_wr_q || is_owned(lk_state));
  assign local_done   = busy_q && local_ok && !snp_valid;
  assign need_bus     = busy_q && !local_ok;
  assign victim_dirty = (lk_state == LS_MOD) && (lk_tag != r_tag);
  assign cmd_w        = victim_dirty ? BC_WBACK : (rq_wr_q ? BC_READX : BC_READ);
  assign granted      = need_bus && bus_gnt;
  assign fill_done    = granted && (cmd_w != BC_WBACK);
  assign done         = local_done || fill_done;

  assign bus_req   = need_bus;
  assign bus_cmd   = cmd_w;
  assign bus_addr  = victim_dirty ? line_base(lk_tag, r_idx) : line_base(r_tag, r_idx);
  assign bus_wline = lk_line;

  always_comb begin
    cw_en    = granted || (local_done && rq_wr_q);
    cw_state = LS_MOD;
    cw_tag   = r_tag;
    cw_line  = word_put(lk_line, r_sel, rq_wdata_q);
    if (granted) begin
      unique case (cmd_w)
        BC_WBACK: begin
          cw_state = LS_INV;
          cw_tag   = lk_tag;
          cw_line  = lk_line;
        end
        BC_READ: begin
          cw_state = bus_shared_in ? LS_SHR : LS_EXC;
          cw_line  = bus_rline;
        end
        default: cw_line = word_put(bus_rline, r_sel, rq_wdata_q);
      endcase
    end
    rdata_next = granted ? word_get(bus_rline, r_sel) : word_get(lk_line, r_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      rq_wr_q     <= 1'b0;
      rq_addr_q   <= '0;
      rq_wdata_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= done;
      if (done) begin
        rsp_rdata_q <= rdata_next;
        busy_q      <= 1'b0;
      end else if (accept) begin
        busy_q     <= 1'b1;
        rq_wr_q    <= core_req_write;
        rq_addr_q  <= core_req_addr;
        rq_wdata_q <= core_req_wdata;
      end
    end
  end

  assign core_req_ready = !busy_q;
  assign core_rsp_valid = rsp_valid_q;
  assign core_rsp_rdata = rsp_rdata_q;

  // snoop side
  assign snp_shared   = sn_hit;
  assign mem_wb_valid = sn_flush;
  assign mem_wb_addr  = line_base(tag_of(snp_addr), sn_idx);
  assign mem_wb_line  = sn_line;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);

  // R10
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !core_req_ready);

  // R10
  rsp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_valid |-> core_req_ready);

  // R6
  m_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && (snp_cmd == 2'd1) && snp_shared && (sn_state == LS_MOD) |-> mem_wb_valid);

  // R8
  victim_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && (bus_cmd == 2'd3) |-> (idx_of(bus_addr) == r_idx) && (tag_of(bus_addr) != r_tag));

  // R5
  rdx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && (bus_cmd == 2'd2) |=> core_rsp_valid);
endmodule

// File: tb/mesi_ctrl_tb_top.sv
module mesi_ctrl_tb_top;
  localparam int LW = 512;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic          rq_v   [2];
  logic          rq_w   [2];
  logic [31:0]   rq_a   [2];
  logic [31:0]   rq_d   [2];
  logic          rdy    [2];
  logic          rsp_v  [2];
  logic [31:0]   rsp_d  [2];
  logic          breq   [2];
  logic [1:0]    bcmd   [2];
  logic [31:0]   baddr  [2];
  logic [LW-1:0] bwline [2];
  logic          gnt    [2];
  logic [LW-1:0] rline  [2];
  logic          shin   [2];
  logic          sv     [2];
  logic [1:0]    sc     [2];
  logic [31:0]   sa     [2];
  logic          sshr   [2];
  logic          wbv    [2];
  logic [31:0]   wba    [2];
  logic [LW-1:0] wbl    [2];

  mesi_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid(rq_v[0]), .core_req_write(rq_w[0]), .core_req_addr(rq_a[0]),
    .core_req_wdata(rq_d[0]), .core_req_ready(rdy[0]), .core_rsp_valid(rsp_v[0]),
    .core_rsp_rdata(rsp_d[0]), .bus_req(breq[0]), .bus_cmd(bcmd[0]), .bus_addr(baddr[0]),
    .bus_wline(bwline[0]), .bus_gnt(gnt[0]), .bus_rline(rline[0]), .bus_shared_in(shin[0]),
    .snp_valid(sv[0]), .snp_cmd(sc[0]), .snp_addr(sa[0]), .snp_shared(sshr[0]),
    .mem_wb_valid(wbv[0]), .mem_wb_addr(wba[0]), .mem_wb_line(wbl[0]));

  mesi_ctrl peer_i (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid(rq_v[1]), .core_req_write(rq_w[1]), .core_req_addr(rq_a[1]),
    .core_req_wdata(rq_d[1]), .core_req_ready(rdy[1]), .core_rsp_valid(rsp_v[1]),
    .core_rsp_rdata(rsp_d[1]), .bus_req(breq[1]), .bus_cmd(bcmd[1]), .bus_addr(baddr[1]),
    .bus_wline(bwline[1]), .bus_gnt(gnt[1]), .bus_rline(rline[1]), .bus_shared_in(shin[1]),
    .snp_valid(sv[1]), .snp_cmd(sc[1]), .snp_addr(sa[1]), .snp_shared(sshr[1]),
    .mem_wb_valid(wbv[1]), .mem_wb_addr(wba[1]), .mem_wb_line(wbl[1]));

  function automatic logic [31:0] init_word(logic [9:0] wa);
    return {6'h2B, wa, wa ^ 10'h155, 6'h01};
  endfunction

  // shared bus: cache 0 has fixed priority, memory of 64 lines
  logic [LW-1:0] mem [64];

  always_comb begin
    gnt[0] = breq[0];
    gnt[1] = breq[1] && !breq[0];
    sv[1] = gnt[0] && (bcmd[0] != 2'd3);  sc[1] = bcmd[0];  sa[1] = baddr[0];
    sv[0] = gnt[1] && (bcmd[1] != 2'd3);  sc[0] = bcmd[1];  sa[0] = baddr[1];
    rline[0] = wbv[1] ? wbl[1] : mem[baddr[0][11:6]];
    rline[1] = wbv[0] ? wbl[0] : mem[baddr[1][11:6]];
    shin[0] = sshr[1];
    shin[1] = sshr[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < 64; l++)
        for (int w = 0; w < 16; w++)
          mem[l][w*32 +: 32] <= init_word({l[5:0], w[3:0]});
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (wbv[c]) mem[wba[c][11:6]] <= wbl[c];
        if (gnt[c] && bcmd[c] == 2'd3) mem[baddr[c][11:6]] <= bwline[c];
      end
    end
  end

  // reference model
  int          n_chk = 0, n_err = 0, stall_cnt = 0;
  int          mst [2][16];
  logic [21:0] mtg [2][16];
  logic [31:0] gold [1024];
  logic [35:0] exq0 [$];
  logic [35:0] exq1 [$];

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(int c, logic [1:0] cmd, logic sh, logic fl, logic [31:0] a);
    if (c == 0) exq0.push_back({cmd, sh, fl, a});
    else        exq1.push_back({cmd, sh, fl, a});
  endtask

  function automatic int qsize(int c);
    return (c == 0) ? exq0.size() : exq1.size();
  endfunction

  task automatic predict(int c, bit wr, logic [31:0] a);
    int o = 1 - c;
    int ix = int'(a[9:6]);
    logic [21:0] tg = a[31:10];
    int st = mst[c][ix];
    bit hit = (st != 0) && (mtg[c][ix] == tg);
    bit ohold, ofl;
    if (hit && (!wr || st >= 2)) begin
      if (wr) mst[c][ix] = 3;
      return;
    end
    if (st == 3 && mtg[c][ix] != tg) begin
      push_exp(c, 2'd3, 1'b0, 1'b0, {mtg[c][ix], a[9:6], 6'd0});
      mst[c][ix] = 0;
    end
    ohold = (mst[o][ix] != 0) && (mtg[o][ix] == tg);
    ofl   = ohold && (mst[o][ix] == 3);
    if (!wr) begin
      push_exp(c, 2'd1, ohold, ofl, {tg, a[9:6], 6'd0});
      if (ohold) mst[o][ix] = 1;
      mst[c][ix] = ohold ? 1 : 2;
    end else begin
      push_exp(c, 2'd2, ohold, ofl, {tg, a[9:6], 6'd0});
      if (ohold) mst[o][ix] = 0;
      mst[c][ix] = 3;
    end
    mtg[c][ix] = tg;
  endtask

  // per-clock comparison of every granted transaction
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        if (breq[c] && !gnt[c]) stall_cnt++;
        if (breq[c] && gnt[c]) begin
          logic [35:0] e;
          string rq;
          if (qsize(c) == 0) begin
            chk(1'b0, "R9", "unexpected bus transaction", {30'd0, bcmd[c], baddr[c]}, 64'd0);
          end else begin
            e = (c == 0) ? exq0.pop_front() : exq1.pop_front();
            rq = (e[35:34] == 2'd1) ? "R2" : (e[35:34] == 2'd2) ? "R5" : "R8";
            chk(bcmd[c] == e[35:34], rq, "bus command", 64'(bcmd[c]), 64'(e[35:34]));
            chk(baddr[c] == e[31:0], rq, "bus address", 64'(baddr[c]), 64'(e[31:0]));
            if (e[35:34] != 2'd3) begin
              chk(shin[c] == e[33], "R6", "shared response", 64'(shin[c]), 64'(e[33]));
              chk(wbv[1-c] == e[32], (e[35:34] == 2'd1) ? "R6" : "R7",
                  "peer flush", 64'(wbv[1-c]), 64'(e[32]));
            end
          end
        end
      end
    end
  end

  task automatic run_op(int c, bit wr, logic [31:0] a, logic [31:0] d, string tag);
    logic [31:0] exp_d;
    bit rdy_seen = 0;
    int waited = 0;
    predict(c, wr, a);
    exp_d = gold[a[11:2]];
    if (wr) gold[a[11:2]] = d;
    while (!rdy[c]) @(negedge clk);
    rq_v[c] = 1'b1; rq_w[c] = wr; rq_a[c] = a; rq_d[c] = d;
    @(negedge clk);
    rq_v[c] = 1'b0;
    while (!rsp_v[c] && waited < 200) begin
      if (rdy[c]) rdy_seen = 1;
      @(negedge clk);
      waited++;
    end
    chk(!rdy_seen, "R10", "ready while busy", 64'(rdy_seen), 64'd0);
    chk(rsp_v[c], tag, "response arrived", 64'(rsp_v[c]), 64'd1);
    if (!wr) chk(rsp_d[c] == exp_d, tag, "read data", 64'(rsp_d[c]), 64'(exp_d));
    chk(qsize(c) == 0, tag, "pending bus transactions", 64'(qsize(c)), 64'd0);
  endtask

  task automatic run_pair(bit wa, logic [31:0] aa, logic [31:0] da,
                          bit wb, logic [31:0] ab, logic [31:0] db, string tag);
    logic [31:0] ea, eb, ga, gb;
    bit fa = 0, fb = 0;
    int waited = 0;
    predict(0, wa, aa);
    ea = gold[aa[11:2]];
    if (wa) gold[aa[11:2]] = da;
    predict(1, wb, ab);
    eb = gold[ab[11:2]];
    if (wb) gold[ab[11:2]] = db;
    while (!rdy[0] || !rdy[1]) @(negedge clk);
    rq_v[0] = 1'b1; rq_w[0] = wa; rq_a[0] = aa; rq_d[0] = da;
    rq_v[1] = 1'b1; rq_w[1] = wb; rq_a[1] = ab; rq_d[1] = db;
    @(negedge clk);
    rq_v[0] = 1'b0; rq_v[1] = 1'b0;
    while (!(fa && fb) && waited < 200) begin
      if (rsp_v[0]) begin fa = 1; ga = rsp_d[0]; end
      if (rsp_v[1]) begin fb = 1; gb = rsp_d[1]; end
      if (!(fa && fb)) @(negedge clk);
      waited++;
    end
    chk(fa && fb, tag, "both responses", {62'd0, fa, fb}, 64'd3);
    if (!wa) chk(ga == ea, tag, "core0 read data", 64'(ga), 64'(ea));
    if (!wb) chk(gb == eb, tag, "core1 read data", 64'(gb), 64'(eb));
    chk(qsize(0) == 0 && qsize(1) == 0, tag, "pending bus transactions",
        64'(qsize(0) + qsize(1)), 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int c = 0; c < 2; c++) begin
      rq_v[c] = 0; rq_w[c] = 0; rq_a[c] = '0; rq_d[c] = '0;
      for (int i = 0; i < 16; i++) begin mst[c][i] = 0; mtg[c][i] = '0; end
    end
    for (int i = 0; i < 1024; i++) gold[i] = init_word(i[9:0]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rdy[0] && rdy[1], "R1", "ready after reset", {62'd0, rdy[0], rdy[1]}, 64'd3);
    chk(!breq[0] && !breq[1], "R1", "bus idle after reset", {62'd0, breq[0], breq[1]}, 64'd0);
    chk(!rsp_v[0] && !rsp_v[1] && !wbv[0] && !wbv[1], "R1", "no response or flush",
        {60'd0, rsp_v[0], rsp_v[1], wbv[0], wbv[1]}, 64'd0);

    run_op(0, 0, 32'h040, 0, "R1");               // absent line misses, fills E (R2)
    run_op(0, 0, 32'h044, 0, "R3");               // hit, no bus
    run_op(0, 1, 32'h048, 32'h1111_2222, "R4");   // E to M silently
    run_op(0, 0, 32'h048, 0, "R3");               // hit in M
    run_op(1, 0, 32'h048, 0, "R6");               // snooped read of M: flush, both S
    run_op(1, 1, 32'h040, 32'h3333_4444, "R5");   // write on S: read-exclusive
    run_op(0, 0, 32'h040, 0, "R11");              // sees peer's value
    run_op(0, 1, 32'h080, 32'h5555_6666, "R5");   // write miss on I
    run_op(0, 0, 32'h480, 0, "R8");               // dirty victim written back first
    run_op(1, 0, 32'h080, 0, "R8");               // memory holds the written-back value
    run_op(0, 0, 32'h100, 0, "R2");
    run_op(0, 0, 32'h500, 0, "R8");               // clean victim, no write-back
    run_op(1, 1, 32'h140, 32'h7777_8888, "R5");
    run_op(0, 1, 32'h144, 32'h9999_AAAA, "R7");   // snooped read-exclusive of M
    run_op(1, 0, 32'h144, 0, "R11");
    run_op(1, 0, 32'h140, 0, "R11");
    run_pair(0, 32'h180, 0, 1, 32'h184, 32'hBBBB_CCCC, "R9");
    run_op(0, 0, 32'h184, 0, "R11");
    run_op(1, 1, 32'h1C0, 32'hDDDD_EEEE, "R5");
    run_pair(0, 32'h1C0, 0, 0, 32'h5C0, 0, "R8");  // waiting victim cleaned by snoop
    run_op(1, 0, 32'h1C0, 0, "R11");
    chk(stall_cnt > 0, "R9", "request held while another cache owned the bus",
        64'(stall_cnt), 64'd1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule